// File: doc/BRIEF.md
# Soft Mute Ramp Sequencer

This block steps a digital gain code between silence (code 0) and unity (all ones) whenever the requested audio state changes. The code drives an external attenuator, which is not part of this block. A gradual ramp avoids audible clicks at the output. The block also reports, with a one-cycle pulse, the moment the output reaches silence, so power management can safely switch off the output stage. An unmute does not start until power management reports that the output stage is ready.

The ramp always has the same number of gain steps: one step for every code between 0 and full scale. A common prescaler produces a base tick every `TICK_DIV` clocks. A 2-bit time select sets the step period to `TICK_DIV << time_sel` clocks, so each code doubles the length of the ramp. When soft ramping is disabled, the gain jumps to its new value in one cycle. In the pin-strapped (hardwired) mode, ramping is forced on and the longest period is always used. Once a ramp has started, it always runs to completion. The request level present when the ramp ends decides what happens next.

The FSM has five states. MUTED holds gain 0. WAIT_PWR holds an unmute that is pending until power is ready. RAMP_UP and RAMP_DOWN step the gain. ACTIVE holds full gain. The transitions are:
- MUTED→WAIT_PWR when the unmute request goes high.
- WAIT_PWR→MUTED when the request is withdrawn.
- WAIT_PWR→RAMP_UP when power is ready and ramping is soft.
- WAIT_PWR→ACTIVE when power is ready and the jump is hard.
- RAMP_UP→ACTIVE on the last step.
- ACTIVE→RAMP_DOWN when the request drops and ramping is soft.
- ACTIVE→MUTED when the request drops and the jump is hard.
- RAMP_DOWN→MUTED on the last step.

Top module: `soft_mute_seq`

## Requirements
- R1: After reset the state is MUTED, with gain 0, busy low and mute_done low.
- R2: With soft ramping and time_sel=0, a mute takes gain from full scale (15 at GAIN_W=4) down to 0, one code at a time. Each step lasts P = TICK_DIV clocks, so the ramp takes 15·P clocks. An unmute climbs the same way.
- R3: The step period is TICK_DIV·2^time_sel clocks for time_sel codes 0, 1, 2 and 3, so each code doubles the ramp length.
- R4: With soft_en=0 and hw_mode=0, the gain jumps to full scale (on unmute) or to 0 (on mute) one clock after the decision.
- R5: With hw_mode=1, ramping is soft whatever soft_en is, and the step period is TICK_DIV·8 whatever time_sel is.
- R6: While pwr_ready is low, a pending unmute keeps the gain at 0 and busy low. The rising ramp starts on the clock after pwr_ready is seen high.
- R7: A request of the opposite sense during a ramp does not alter the ramp. It is acted on when the ramp ends.
- R8: busy is high from the clock after a ramp starts until the clock on which its last step lands.
- R9: mute_done is high for exactly one cycle, right after the gain reaches 0 from a non-zero value.
- R10: time_sel is captured when a ramp starts. Changing it mid-ramp leaves that ramp's period unchanged and affects only the next ramp.
- R11: An unmute request withdrawn while waiting for power returns the block to MUTED. No ramp and no mute_done pulse follow, even if pwr_ready then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unmute_req | input | 1 | Requested state: 1 audible, 0 muted |
| soft_en | input | 1 | 1 ramps the gain, 0 jumps it |
| time_sel | input | 2 | Ramp length select; step period TICK_DIV·2^code |
| hw_mode | input | 1 | Pin-strapped mode: force soft ramp at the longest period |
| pwr_ready | input | 1 | Output stage powered and ready for unmute |
| gain | output | GAIN_W | Gain code to the attenuator |
| busy | output | 1 | High while a ramp is in progress |
| mute_done | output | 1 | One-cycle pulse when gain has reached 0 |

## Verification
The bench sets a request at a falling edge and counts the rising edges on the way to each result:
- A mute starts its ramp on the next edge.
- An unmute spends one edge in WAIT_PWR and starts its ramp on the following edge.
- During a ramp, the gain after n further edges must equal n/P (rising) or 15−n/P (falling), where P = TICK_DIV·2^sel.
- busy drops, and mute_done rises, on the edge of the last step.
- Hard jumps show their result one edge after the decision.

Every output is sampled at the falling edge after the edge where it is due. The ramp is compared against this formula on every cycle, for all four time codes in both directions.

// File: rtl/smute_pkg.sv
package smute_pkg;

    localparam int unsigned SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_LONGEST = '1;

    typedef enum logic [2:0] {
        ST_MUTED,
        ST_WAIT_PWR,
        ST_RAMP_UP,
        ST_ACTIVE,
        ST_RAMP_DOWN
    } smute_state_t;

endpackage

// File: rtl/smute_step_timer.sv
module smute_step_timer #(
    parameter int unsigned TICK_DIV = 4,
    parameter int unsigned SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);
    localparam int unsigned PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned SCL_W = ((1 << SEL_W) - 1 > 0) ? (1 << SEL_W) - 1 : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [SCL_W-1:0] scl_q;
    logic [SCL_W-1:0] scl_lim;
    logic [SEL_W-1:0] sel_q;
    logic             tick;

    // scaler limit is 2^sel - 1: the low sel bits set
    always_comb begin
        scl_lim = '0;
        for (int b = 0; b < SCL_W; b++) begin
            scl_lim[b] = (b < int'(sel_q));
        end
    end

    assign tick = run && (pre_q == PRE_LAST);
    assign step = tick && (scl_q == scl_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            scl_q <= '0;
            sel_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
            scl_q <= '0;
            sel_q <= sel;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                scl_q <= step ? '0 : scl_q + 1'b1;
            end
        end
    end

    // R10: a ramp never runs on a period that was not captured at its start
    assert_restart_before_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(restart));

endmodule

// File: rtl/smute_gain.sv
module smute_gain #(
    parameter int unsigned GAIN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              load_full,
    input  logic              clear,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] GAIN_FULL = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= '0;
        end else if (clear) begin
            gain <= '0;
        end else if (load_full) begin
            gain <= GAIN_FULL;
        end else if (inc) begin
            gain <= gain + 1'b1;
        end else if (dec) begin
            gain <= gain - 1'b1;
        end
    end

    assert_single_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc, dec, load_full, clear}));

    assert_no_wrap_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (gain != GAIN_FULL));

    assert_no_wrap_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (gain != '0));

endmodule

// File: rtl/soft_mute_seq.sv
module soft_mute_seq
    import smute_pkg::*;
#(
    parameter int unsigned GAIN_W   = 4,
    parameter int unsigned TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unmute_req,
    input  logic              soft_en,
    input  logic [1:0]        time_sel,
    input  logic              hw_mode,
    input  logic              pwr_ready,
    output logic [GAIN_W-1:0] gain,
    output logic              busy,
    output logic              mute_done
);
    localparam logic [GAIN_W-1:0] GAIN_FULL = '1;
    localparam logic [GAIN_W-1:0] GAIN_NEAR = GAIN_FULL - 1'b1;
    localparam logic [GAIN_W-1:0] GAIN_ONE  = {{(GAIN_W-1){1'b0}}, 1'b1};

    smute_state_t state_q, state_d;

    logic             soft_eff;
    logic [SEL_W-1:0] sel_eff;
    logic             t_restart, t_run, t_step;
    logic             g_inc, g_dec, g_full, g_clr;
    logic             done_set;

    assign soft_eff = soft_en | hw_mode;
    assign sel_eff  = hw_mode ? SEL_LONGEST : time_sel;

    smute_step_timer #(
        .TICK_DIV (TICK_DIV),
        .SEL_W    (SEL_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (t_restart),
        .run     (t_run),
        .sel     (sel_eff),
        .step    (t_step)
    );

    smute_gain #(
        .GAIN_W (GAIN_W)
    ) u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (g_inc),
        .dec       (g_dec),
        .load_full (g_full),
        .clear     (g_clr),
        .gain      (gain)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MUTED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath controls
    always_comb begin
        state_d   = state_q;
        t_restart = 1'b0;
        t_run     = 1'b0;
        g_inc     = 1'b0;
        g_dec     = 1'b0;
        g_full    = 1'b0;
        g_clr     = 1'b0;
        done_set  = 1'b0;
        unique case (state_q)
            ST_MUTED: begin
                if (unmute_req) begin
                    state_d = ST_WAIT_PWR;
                end
            end
            ST_WAIT_PWR: begin
                if (!unmute_req) begin
                    state_d = ST_MUTED;
                end else if (pwr_ready) begin
                    if (soft_eff) begin
                        state_d   = ST_RAMP_UP;
                        t_restart = 1'b1;
                    end else begin
                        state_d = ST_ACTIVE;
                        g_full  = 1'b1;
                    end
                end
            end
            ST_RAMP_UP: begin
                t_run = 1'b1;
                if (t_step) begin
                    g_inc = 1'b1;
                    if (gain == GAIN_NEAR) begin
                        state_d = ST_ACTIVE;
                    end
                end
            end
            ST_ACTIVE: begin
                if (!unmute_req) begin
                    if (soft_eff) begin
                        state_d   = ST_RAMP_DOWN;
                        t_restart = 1'b1;
                    end else begin
                        state_d  = ST_MUTED;
                        g_clr    = 1'b1;
                        done_set = 1'b1;
                    end
                end
            end
            ST_RAMP_DOWN: begin
                t_run = 1'b1;
                if (t_step) begin
                    g_dec = 1'b1;
                    if (gain == GAIN_ONE) begin
                        state_d  = ST_MUTED;
                        done_set = 1'b1;
                    end
                end
            end
            default: state_d = ST_MUTED;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mute_done <= 1'b0;
        end else begin
            mute_done <= done_set;
        end
    end

    assign busy = (state_q == ST_RAMP_UP) || (state_q == ST_RAMP_DOWN);

    assert_muted_gain_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED) |-> (gain == '0));

    assert_ramp_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((gain == $past(gain)) || ({1'b0, gain} == {1'b0, $past(gain)} + 1'b1)
                  || ({1'b0, gain} + 1'b1 == {1'b0, $past(gain)})));

    assert_ready_before_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RAMP_UP) && ($past(state_q) == ST_WAIT_PWR)) |-> $past(pwr_ready));

    assert_no_cancel_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP_DOWN) |=> ((state_q == ST_RAMP_DOWN) || (state_q == ST_MUTED)));

    assert_no_cancel_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP_UP) |=> ((state_q == ST_RAMP_UP) || (state_q == ST_ACTIVE)));

    assert_done_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mute_done |-> ((gain == '0) && !busy));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mute_done |=> !mute_done);

endmodule

// File: tb/soft_mute_seq_tb.sv
module soft_mute_seq_tb;

    localparam int GAIN_W   = 4;
    localparam int TICK_DIV = 4;
    localparam int GMAX     = (1 << GAIN_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              unmute_req;
    logic              soft_en;
    logic [1:0]        time_sel;
    logic              hw_mode;
    logic              pwr_ready;
    logic [GAIN_W-1:0] gain;
    logic              busy;
    logic              mute_done;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    soft_mute_seq #(
        .GAIN_W   (GAIN_W),
        .TICK_DIV (TICK_DIV)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .unmute_req (unmute_req),
        .soft_en    (soft_en),
        .time_sel   (time_sel),
        .hw_mode    (hw_mode),
        .pwr_ready  (pwr_ready),
        .gain       (gain),
        .busy       (busy),
        .mute_done  (mute_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic check_idle(input string req, input int exp_gain);
        check(int'(gain) == exp_gain, req, int'(gain), exp_gain);
        check(busy == 1'b0, req, int'(busy), 0);
    endtask

    // Called at a falling edge just after the edge that started the ramp.
    task automatic ramp(input bit up, input int sel, input int flip_at,
                        input int chg_at, input string tag);
        int p     = TICK_DIV << sel;
        int total = GMAX * p;
        for (int n = 0; n <= total; n++) begin
            int exp;
            if (n > 0) @(negedge clk);
            exp = up ? (n / p) : (GMAX - n / p);
            check(int'(gain) == exp, tag, int'(gain), exp);
            check(busy == (n < total), "R8", int'(busy), int'(n < total));
            check(mute_done == (!up && n == total), "R9", int'(mute_done),
                  int'(!up && n == total));
            if (n == flip_at) unmute_req = up ? 1'b0 : 1'b1;
            if (n == chg_at) time_sel = ~time_sel;
        end
    endtask

    // at a falling edge: request unmute with power ready, then check the ramp
    task automatic soft_unmute(input int sel, input int chg_at, input string tag);
        unmute_req = 1'b1;
        @(negedge clk);
        check_idle("R6", 0);          // WAIT_PWR for one edge
        @(negedge clk);
        ramp(1'b1, sel, -1, chg_at, tag);
    endtask

    task automatic soft_mute(input int sel, input string tag);
        unmute_req = 1'b0;
        @(negedge clk);
        ramp(1'b0, sel, -1, -1, tag);
        @(negedge clk);
        check(mute_done == 1'b0, "R9", int'(mute_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        unmute_req = 1'b0;
        soft_en    = 1'b1;
        time_sel   = 2'd3;
        hw_mode    = 1'b0;
        pwr_ready  = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_idle("R1", 0);
        check(mute_done == 1'b0, "R1", int'(mute_done), 0);

        // R2 / R3 sweep of all time codes, both directions
        for (int s = 0; s < 4; s++) begin
            time_sel = 2'(s);
            soft_unmute(s, -1, (s == 0) ? "R2" : "R3");
            soft_mute(s, (s == 0) ? "R2" : "R3");
        end

        // R10: change time_sel mid-ramp; the ramp keeps code 2, the next uses code 1
        time_sel = 2'd2;
        soft_unmute(2, 3, "R10");
        soft_mute(1, "R10");

        // R7: opposite requests during ramps are deferred
        time_sel = 2'd0;
        soft_unmute(0, -1, "R7");
        unmute_req = 1'b0;
        @(negedge clk);
        ramp(1'b0, 0, 10, -1, "R7");        // unmute requested at n=10
        @(negedge clk);
        check_idle("R7", 0);                 // WAIT_PWR after the ramp ended
        @(negedge clk);
        ramp(1'b1, 0, 7, -1, "R7");         // mute requested at n=7
        @(negedge clk);
        ramp(1'b0, 0, -1, -1, "R7");
        @(negedge clk);
        check(mute_done == 1'b0, "R9", int'(mute_done), 0);

        // R4: hard jumps
        soft_en    = 1'b0;
        unmute_req = 1'b1;
        @(negedge clk);
        check_idle("R4", 0);
        @(negedge clk);
        check_idle("R4", GMAX);
        repeat (5) begin
            @(negedge clk);
            check_idle("R4", GMAX);
        end
        unmute_req = 1'b0;
        @(negedge clk);
        check_idle("R4", 0);
        check(mute_done == 1'b1, "R9", int'(mute_done), 1);
        @(negedge clk);
        check(mute_done == 1'b0, "R9", int'(mute_done), 0);

        // R5: hardwired mode forces soft ramp at the longest period
        hw_mode  = 1'b1;
        soft_en  = 1'b0;
        time_sel = 2'd0;
        soft_unmute(3, -1, "R5");
        soft_mute(3, "R5");
        hw_mode = 1'b0;
        soft_en = 1'b1;

        // R6: unmute waits for power ready
        time_sel   = 2'd1;
        pwr_ready  = 1'b0;
        unmute_req = 1'b1;
        repeat (20) begin
            @(negedge clk);
            check_idle("R6", 0);
        end
        pwr_ready = 1'b1;
        @(negedge clk);
        ramp(1'b1, 1, -1, -1, "R6");
        soft_mute(1, "R6");

        // R11: withdrawn unmute while waiting
        pwr_ready  = 1'b0;
        unmute_req = 1'b1;
        repeat (3) @(negedge clk);
        unmute_req = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_idle("R11", 0);
        end
        pwr_ready = 1'b1;
        repeat (10) begin
            @(negedge clk);
            check_idle("R11", 0);
            check(mute_done == 1'b0, "R11", int'(mute_done), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule